// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block converts single internal read or write requests into timed cycles on an external parallel memory bus. Each accepted request runs to completion before another is taken. The cycle's shape is fixed at acceptance from a set of configuration inputs:
- the bus mode: address and data sharing one port, or on separate ports;
- the data width, 8 or 16 bits;
- the number of live address bits;
- the number of wait states;
- the address-strobe length;
- an optional extra clock before the read/write strobe;
- an optional turnaround clock after reads;
- whether the external ready input may extend the cycle.

Every cycle is a walk through one enumerated state machine. The states are ST_IDLE, ST_ADDR (address strobe high), ST_DELAY (optional gap before the strobe), ST_STROBE (read or write strobe low), ST_TURN (bus release after a read) and ST_HOLD (bus handed to another master).

The transitions are these:
- ST_IDLE goes to ST_HOLD on a hold request. Otherwise it goes to ST_ADDR on a valid request.
- ST_ADDR stays one extra clock when the long strobe is chosen. It then goes to ST_DELAY if the delay is enabled, and to ST_STROBE if not.
- ST_DELAY goes to ST_STROBE.
- ST_STROBE leaves when the wait counter is zero and ready allows. It goes to ST_TURN after a read with turnaround enabled, and to ST_IDLE otherwise.
- ST_TURN goes to ST_IDLE.
- ST_HOLD goes back to ST_IDLE when the hold request drops.

Top module: `ebus_seq_top`

## Requirements
- R1: After reset: bus_ale is 0, bus_rd_n and bus_wr_n are 1, hold_ack is 0, rsp_done is 0, req_ready is 1 (with hold_req low) and bus_ad_oe is 2'b00.
- R2: In separate-port mode (cfg_mux=0), bus_addr carries the address from the first ALE clock until the strobe ends. bus_ad_oe is 2'b00 while bus_ale is high. During a 16-bit write strobe, bus_ad_oe is 2'b11 and bus_ad_out equals the write data.
- R3: In shared-port mode (cfg_mux=1), bus_ale is high for 1 clock when cfg_ale_long=0 and for 2 clocks when cfg_ale_long=1. While it is high, bus_ad_oe is 2'b11 and bus_ad_out carries address bits 15:0. ALE is never high for more than 2 consecutive clocks.
- R4: cfg_aw selects the live address bits: 0 selects 16, 1 selects 18, 2 selects 20 and 3 selects 24. Bits of bus_addr above the selected width are driven 0.
- R5: With cfg_rdy_en=0, the strobe is low for exactly cfg_waits+1 clocks (cfg_waits 0..15), and bus_ready has no effect.
- R6: cfg_rw_delay=1 inserts exactly one clock between ALE falling and the strobe falling, with both high. With cfg_rw_delay=0 the strobe falls right after ALE.
- R7: With cfg_rdy_en=1, the strobe stays low until a clock in which the wait count has expired and bus_ready is 1. Its length is therefore max(cfg_waits+1, clocks until ready).
- R8: Data lanes. 16-bit word reads return bus_ad_in whole. 16-bit byte reads return the high byte for an odd address and the low byte for an even one, in rsp_rdata[7:0]. 16-bit byte writes put the byte on both lanes. In 8-bit mode (cfg_wide=0) only lane 0 is used: reads return {8'h00, bus_ad_in[7:0]} and writes drive bus_ad_oe=2'b01.
- R9: bus_bhe_n is 0 during a cycle only in 16-bit mode, and only when the access is a word or an odd-address byte. Otherwise it is 1.
- R10: bus_ad_oe is 2'b00 while bus_rd_n is low. With cfg_turn=1, a read is followed by one clock in which req_ready is 0 and bus_ad_oe is 2'b00. Writes never get a turnaround clock.
- R11: hold_ack rises only from idle after hold_req, and never during a running cycle. While it is high, bus_addr_oe, bus_strb_oe and bus_ad_oe are 0 and requests are stalled. It falls one clock after hold_req falls.
- R12: req_ready is high only in idle. rsp_done is a one-clock pulse one clock after the strobe ends, with rsp_rdata valid for a read.
- R13: bus_rd_n and bus_wr_n are never both low, and ALE never overlaps a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| cfg_mux | input | 1 | 1 = shared address/data port |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cfg_aw | input | 2 | Address width code |
| cfg_waits | input | WAIT_W | Wait states |
| cfg_ale_long | input | 1 | 1 = two-clock ALE |
| cfg_rw_delay | input | 1 | 1 = one clock before strobe |
| cfg_turn | input | 1 | 1 = turnaround clock after reads |
| cfg_rdy_en | input | 1 | 1 = bus_ready extends strobe |
| bus_addr | output | ADDR_W | Address lines |
| bus_addr_oe | output | 1 | Address line driver enable |
| bus_ad_out | output | DATA_W | Data (or shared address) output |
| bus_ad_in | input | DATA_W | Data input |
| bus_ad_oe | output | DATA_W/8 | Per-byte data driver enable |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_strb_oe | output | 1 | Strobe driver enable |
| bus_ready | input | 1 | External ready |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus released to external master |

## Verification
The assertions watch properties that must hold on every clock:
- the two strobes are exclusive, and ALE never overlaps a strobe;
- ALE is never longer than two clocks;
- the data drivers stay released while the read strobe is low;
- the hold handover floats every output and rises and falls at the right moments;
- the completion pulse lasts one clock;
- req_ready is seen only in idle.

Only the directed scenarios can show the values that depend on configuration:
- the exact strobe length for given wait states and ready timing;
- the address masking per width code;
- the lane steering and byte-high enable;
- the delay gap and the turnaround clock;
- the correct read data.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int WAIT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DELAY,
        ST_STROBE,
        ST_TURN,
        ST_HOLD
    } ebus_state_e;

    typedef enum logic [1:0] {
        AW_16 = 2'd0,
        AW_18 = 2'd1,
        AW_20 = 2'd2,
        AW_24 = 2'd3
    } ebus_aw_e;

    typedef struct packed {
        logic              mux;
        logic              wide;
        ebus_aw_e          aw;
        logic [WAIT_W-1:0] waits;
        logic              ale_long;
        logic              rw_delay;
        logic              turn;
        logic              rdy_en;
    } ebus_cfg_t;

    function automatic int aw_bits(ebus_aw_e code);
        int bits;
        unique case (code)
            AW_16:   bits = 16;
            AW_18:   bits = 18;
            AW_20:   bits = 20;
            default: bits = 24;
        endcase
        return bits;
    endfunction

endpackage

// File: rtl/ebus_wait_ctr.sv
module ebus_wait_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ebus_addr_map.sv
module ebus_addr_map
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  ebus_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               byte_acc,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  ad_in,
    output logic [ADDR_W-1:0]  addr_masked,
    output logic               upper_lane,
    output logic [DATA_W-1:0]  wlane,
    output logic [DATA_W-1:0]  rlane
);

    localparam int BYTE_W = 8;
    localparam int HI_W   = DATA_W - BYTE_W;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign addr_masked[i] = addr[i] & (i < aw_bits(cfg.aw));
    end

    assign upper_lane = cfg.wide && (!byte_acc || addr[0]);

    always_comb begin
        if (!cfg.wide) begin
            wlane = {{HI_W{1'b0}}, wdata[BYTE_W-1:0]};
        end else if (byte_acc) begin
            wlane = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
        end else begin
            wlane = wdata;
        end
    end

    always_comb begin
        if (!cfg.wide) begin
            rlane = {{HI_W{1'b0}}, ad_in[BYTE_W-1:0]};
        end else if (byte_acc && addr[0]) begin
            rlane = {{HI_W{1'b0}}, ad_in[DATA_W-1 -: BYTE_W]};
        end else if (byte_acc) begin
            rlane = {{HI_W{1'b0}}, ad_in[BYTE_W-1:0]};
        end else begin
            rlane = ad_in;
        end
    end

endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_byte,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  ebus_cfg_t             cfg_in,
    input  logic                  hold_req,
    input  logic                  bus_ready,
    input  logic                  wait_zero,
    input  logic [ADDR_W-1:0]     addr_masked,
    input  logic                  upper_lane,
    input  logic [DATA_W-1:0]     wlane,
    input  logic [DATA_W-1:0]     rlane,
    output ebus_cfg_t             cfg_q,
    output logic [ADDR_W-1:0]     addr_q,
    output logic                  byte_q,
    output logic [DATA_W-1:0]     wdata_q,
    output logic                  wait_load,
    output logic                  wait_dec,
    output logic                  req_ready,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_addr_oe,
    output logic [DATA_W-1:0]     bus_ad_out,
    output logic [DATA_W/8-1:0]   bus_ad_oe,
    output logic                  bus_ale,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic                  bus_bhe_n,
    output logic                  bus_strb_oe,
    output logic                  hold_ack
);

    localparam int LANES = DATA_W / 8;

    ebus_state_e state_q, state_d;
    logic        ale_second_q;
    logic        write_q;
    logic        accept;
    logic        finish;
    logic [LANES-1:0] data_lanes;

    assign accept = (state_q == ST_IDLE) && !hold_req && req_valid;
    assign finish = (state_q == ST_STROBE) && wait_zero && (!cfg_q.rdy_en || bus_ready);

    assign wait_load = accept;
    assign wait_dec  = (state_q == ST_STROBE) && !wait_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // second ALE clock marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_second_q <= 1'b0;
        end else begin
            ale_second_q <= (state_q == ST_ADDR);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_req) begin
                    state_d = ST_HOLD;
                end else if (req_valid) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (!(cfg_q.ale_long && !ale_second_q)) begin
                    state_d = cfg_q.rw_delay ? ST_DELAY : ST_STROBE;
                end
            end
            ST_DELAY: state_d = ST_STROBE;
            ST_STROBE: begin
                if (finish) begin
                    state_d = (!write_q && cfg_q.turn) ? ST_TURN : ST_IDLE;
                end
            end
            ST_TURN: state_d = ST_IDLE;
            ST_HOLD: begin
                if (!hold_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            addr_q  <= '0;
            byte_q  <= 1'b0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            cfg_q   <= cfg_in;
            addr_q  <= req_addr;
            byte_q  <= req_byte;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // completion pulse and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= finish;
            if (finish && !write_q) begin
                rsp_rdata <= rlane;
            end
        end
    end

    assign data_lanes = cfg_q.wide ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
    assign bus_addr   = addr_masked;
    assign req_ready  = (state_q == ST_IDLE) && !hold_req;

    // bus outputs
    always_comb begin
        bus_ale     = 1'b0;
        bus_rd_n    = 1'b1;
        bus_wr_n    = 1'b1;
        bus_bhe_n   = 1'b1;
        bus_addr_oe = 1'b1;
        bus_strb_oe = 1'b1;
        bus_ad_oe   = '0;
        bus_ad_out  = wlane;
        hold_ack    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                bus_ale   = 1'b1;
                bus_bhe_n = !upper_lane;
                if (cfg_q.mux) begin
                    bus_ad_oe  = {LANES{1'b1}};
                    bus_ad_out = addr_masked[DATA_W-1:0];
                end
            end
            ST_DELAY: begin
                bus_bhe_n = !upper_lane;
                if (write_q) begin
                    bus_ad_oe = data_lanes;
                end
            end
            ST_STROBE: begin
                bus_bhe_n = !upper_lane;
                bus_rd_n  = write_q;
                bus_wr_n  = !write_q;
                if (write_q) begin
                    bus_ad_oe = data_lanes;
                end
            end
            ST_TURN: ;
            ST_HOLD: begin
                bus_addr_oe = 1'b0;
                bus_strb_oe = 1'b0;
                hold_ack    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ebus_seq_top.sv
module ebus_seq_top
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_byte,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 cfg_mux,
    input  logic                 cfg_wide,
    input  logic [1:0]           cfg_aw,
    input  logic [WAIT_W-1:0]    cfg_waits,
    input  logic                 cfg_ale_long,
    input  logic                 cfg_rw_delay,
    input  logic                 cfg_turn,
    input  logic                 cfg_rdy_en,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_addr_oe,
    output logic [DATA_W-1:0]    bus_ad_out,
    input  logic [DATA_W-1:0]    bus_ad_in,
    output logic [DATA_W/8-1:0]  bus_ad_oe,
    output logic                 bus_ale,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic                 bus_bhe_n,
    output logic                 bus_strb_oe,
    input  logic                 bus_ready,
    input  logic                 hold_req,
    output logic                 hold_ack
);

    ebus_cfg_t         cfg_in, cfg_q;
    logic [ADDR_W-1:0] addr_q, addr_masked;
    logic [DATA_W-1:0] wdata_q, wlane, rlane;
    logic              byte_q, upper_lane;
    logic              wait_load, wait_dec, wait_zero;

    always_comb begin
        cfg_in.mux      = cfg_mux;
        cfg_in.wide     = cfg_wide;
        cfg_in.aw       = ebus_aw_e'(cfg_aw);
        cfg_in.waits    = cfg_waits;
        cfg_in.ale_long = cfg_ale_long;
        cfg_in.rw_delay = cfg_rw_delay;
        cfg_in.turn     = cfg_turn;
        cfg_in.rdy_en   = cfg_rdy_en;
    end

    ebus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_byte    (req_byte),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .cfg_in      (cfg_in),
        .hold_req    (hold_req),
        .bus_ready   (bus_ready),
        .wait_zero   (wait_zero),
        .addr_masked (addr_masked),
        .upper_lane  (upper_lane),
        .wlane       (wlane),
        .rlane       (rlane),
        .cfg_q       (cfg_q),
        .addr_q      (addr_q),
        .byte_q      (byte_q),
        .wdata_q     (wdata_q),
        .wait_load   (wait_load),
        .wait_dec    (wait_dec),
        .req_ready   (req_ready),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .bus_addr    (bus_addr),
        .bus_addr_oe (bus_addr_oe),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_ale     (bus_ale),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_bhe_n   (bus_bhe_n),
        .bus_strb_oe (bus_strb_oe),
        .hold_ack    (hold_ack)
    );

    ebus_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) map_i (
        .cfg         (cfg_q),
        .addr        (addr_q),
        .byte_acc    (byte_q),
        .wdata       (wdata_q),
        .ad_in       (bus_ad_in),
        .addr_masked (addr_masked),
        .upper_lane  (upper_lane),
        .wlane       (wlane),
        .rlane       (rlane)
    );

    ebus_wait_ctr #(.CNT_W(WAIT_W)) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (cfg_in.waits),
        .dec      (wait_dec),
        .zero     (wait_zero)
    );

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ale,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             bus_addr_oe,
    input logic             bus_strb_oe,
    input logic [LANES-1:0] bus_ad_oe,
    input logic             hold_req,
    input logic             hold_ack,
    input logic             req_ready,
    input logic             rsp_done
);

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_ale_no_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

    assert_ale_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && $past(bus_ale)) |=> !bus_ale);

    assert_read_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_ad_oe == '0));

    assert_hold_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!bus_addr_oe && !bus_strb_oe && (bus_ad_oe == '0) && !req_ready));

    assert_hold_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req));

    assert_hold_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rd_n && bus_wr_n && !bus_ale && !hold_ack));

endmodule

bind ebus_seq_top ebus_seq_chk #(.LANES(DATA_W/8)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ale     (bus_ale),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_addr_oe (bus_addr_oe),
    .bus_strb_oe (bus_strb_oe),
    .bus_ad_oe   (bus_ad_oe),
    .hold_req    (hold_req),
    .hold_ack    (hold_ack),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done)
);

// File: tb/ebus_seq_top_tb_top.sv
module ebus_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_byte = 0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic        cfg_mux = 0, cfg_wide = 1, cfg_ale_long = 0, cfg_rw_delay = 0;
    logic        cfg_turn = 0, cfg_rdy_en = 0;
    logic [1:0]  cfg_aw = 2'd3;
    logic [3:0]  cfg_waits = '0;
    logic [23:0] bus_addr;
    logic        bus_addr_oe, bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_strb_oe;
    logic [15:0] bus_ad_out;
    logic [15:0] bus_ad_in = '0;
    logic [1:0]  bus_ad_oe;
    logic        bus_ready = 1'b1;
    logic        hold_req = 1'b0;
    logic        hold_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // per-access observations
    int          m_ale, m_strb, m_gap;
    logic [15:0] m_rd, m_ad_ale, m_out_strb;
    logic [1:0]  m_oe_ale, m_oe_strb, m_oe_done;
    logic [23:0] m_addr, m_addr_strb;
    logic        m_bhe, m_rdy_done, m_done_next, m_rdy_next, m_done_seen;

    always #5 clk = ~clk;

    ebus_seq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_mux(cfg_mux), .cfg_wide(cfg_wide), .cfg_aw(cfg_aw), .cfg_waits(cfg_waits),
        .cfg_ale_long(cfg_ale_long), .cfg_rw_delay(cfg_rw_delay), .cfg_turn(cfg_turn),
        .cfg_rdy_en(cfg_rdy_en),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_ad_out(bus_ad_out),
        .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n),
        .bus_strb_oe(bus_strb_oe), .bus_ready(bus_ready),
        .hold_req(hold_req), .hold_ack(hold_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic mux, input logic wide, input logic [1:0] aw,
                           input logic [3:0] waits, input logic ale_long, input logic dly,
                           input logic turn, input logic rdy);
        cfg_mux = mux; cfg_wide = wide; cfg_aw = aw; cfg_waits = waits;
        cfg_ale_long = ale_long; cfg_rw_delay = dly; cfg_turn = turn; cfg_rdy_en = rdy;
    endtask

    // issue one access and trace it at falling edges until completion
    task automatic do_access(input logic wr, input logic [23:0] addr, input logic [15:0] wd,
                             input logic byt, input int rdy_after);
        m_ale = 0; m_strb = 0; m_gap = 0; m_done_seen = 0;
        m_rd = '0; m_ad_ale = '0; m_out_strb = '0; m_oe_ale = '0; m_oe_strb = '0;
        m_addr = '0; m_addr_strb = '0; m_bhe = 1'b1; m_oe_done = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_byte = byt;
        bus_ready = (rdy_after == 0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (bus_ale) begin
                m_ale++; m_addr = bus_addr; m_ad_ale = bus_ad_out; m_oe_ale = bus_ad_oe;
                m_bhe = bus_bhe_n;
            end else if (!bus_rd_n || !bus_wr_n) begin
                m_strb++; m_oe_strb = bus_ad_oe; m_out_strb = bus_ad_out;
                m_addr_strb = bus_addr;
            end else if (!rsp_done && m_strb == 0 && m_ale > 0) begin
                m_gap++;
            end
            if (rsp_done) begin
                m_rd = rsp_rdata; m_rdy_done = req_ready; m_oe_done = bus_ad_oe;
                m_done_seen = 1'b1;
                break;
            end
            bus_ready = (m_strb >= rdy_after);
            @(negedge clk);
        end
        @(negedge clk);
        m_done_next = rsp_done;
        m_rdy_next  = req_ready;
        bus_ready = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ale", bus_ale, 0);
        chk("R1 rd_n", bus_rd_n, 1);
        chk("R1 wr_n", bus_wr_n, 1);
        chk("R1 hold_ack", hold_ack, 0);
        chk("R1 done", rsp_done, 0);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 ad_oe", bus_ad_oe, 0);
    endtask

    task automatic t_demux();
        set_cfg(0, 1, 2'd3, 4'd2, 0, 0, 0, 0);
        bus_ad_in = 16'hBEEF;
        do_access(0, 24'h123456, 16'h0, 0, 0);
        chk("R2 addr at ale", m_addr, 24'h123456);
        chk("R2 addr at strobe", m_addr_strb, 24'h123456);
        chk("R2 ad_oe at ale", m_oe_ale, 0);
        chk("R5 strobe len w2", m_strb, 3);
        chk("R8 word read", m_rd, 16'hBEEF);
        chk("R9 bhe word", m_bhe, 0);
        chk("R10 read release", m_oe_strb, 0);
        chk("R12 done seen", m_done_seen, 1);
        chk("R12 done one cycle", m_done_next, 0);
        chk("R12 ready at done", m_rdy_done, 1);
        do_access(1, 24'h00ABCE, 16'h1234, 0, 0);
        chk("R2 write oe", m_oe_strb, 2'b11);
        chk("R2 write data", m_out_strb, 16'h1234);
        chk("R2 write addr", m_addr_strb, 24'h00ABCE);
        chk("R6 no delay gap", m_gap, 0);
    endtask

    task automatic t_mux();
        set_cfg(1, 1, 2'd0, 4'd1, 0, 0, 0, 0);
        do_access(1, 24'h009876, 16'h5555, 0, 0);
        chk("R3 ale short", m_ale, 1);
        chk("R3 ad addr", m_ad_ale, 16'h9876);
        chk("R3 ad oe", m_oe_ale, 2'b11);
        chk("R3 data after addr", m_out_strb, 16'h5555);
        cfg_ale_long = 1'b1;
        do_access(0, 24'h004321, 16'h0, 0, 0);
        chk("R3 ale long", m_ale, 2);
        chk("R3 ad addr long", m_ad_ale, 16'h4321);
    endtask

    task automatic t_widths();
        logic [23:0] exp_mask [4];
        exp_mask[0] = 24'h00FFFF; exp_mask[1] = 24'h03FFFF;
        exp_mask[2] = 24'h0FFFFF; exp_mask[3] = 24'hFFFFFF;
        for (int a = 0; a < 4; a++) begin
            set_cfg(0, 1, a[1:0], 4'd0, 0, 0, 0, 0);
            do_access(0, 24'hFFFFFF, 16'h0, 0, 0);
            chk("R4 addr mask", m_addr, exp_mask[a]);
        end
    endtask

    task automatic t_waits();
        set_cfg(0, 1, 2'd3, 4'd0, 0, 0, 0, 0);
        do_access(0, 24'h10, 16'h0, 0, 0);
        chk("R5 strobe len w0", m_strb, 1);
        cfg_waits = 4'd15;
        do_access(1, 24'h10, 16'h0, 0, 0);
        chk("R5 strobe len w15", m_strb, 16);
        cfg_waits = 4'd2;
        do_access(0, 24'h10, 16'h0, 0, 9);
        chk("R5 ready ignored", m_strb, 3);
    endtask

    task automatic t_delay();
        set_cfg(1, 1, 2'd3, 4'd0, 0, 1, 0, 0);
        do_access(0, 24'h20, 16'h0, 0, 0);
        chk("R6 delay gap", m_gap, 1);
        cfg_ale_long = 1'b1;
        do_access(1, 24'h20, 16'h0, 0, 0);
        chk("R6 delay gap long ale", m_gap, 1);
    endtask

    task automatic t_ready();
        set_cfg(0, 1, 2'd3, 4'd2, 0, 0, 0, 1);
        do_access(0, 24'h30, 16'h0, 0, 6);
        chk("R7 ready late", m_strb, 6);
        cfg_waits = 4'd4;
        do_access(0, 24'h30, 16'h0, 0, 2);
        chk("R7 ready early", m_strb, 5);
    endtask

    task automatic t_lanes();
        set_cfg(0, 1, 2'd3, 4'd0, 0, 0, 0, 0);
        bus_ad_in = 16'hA55A;
        do_access(0, 24'h11, 16'h0, 1, 0);
        chk("R8 byte odd", m_rd, 16'h00A5);
        chk("R9 bhe odd byte", m_bhe, 0);
        do_access(0, 24'h10, 16'h0, 1, 0);
        chk("R8 byte even", m_rd, 16'h005A);
        chk("R9 bhe even byte", m_bhe, 1);
        do_access(1, 24'h13, 16'h003C, 1, 0);
        chk("R8 byte write dup", m_out_strb, 16'h3C3C);
        set_cfg(0, 0, 2'd3, 4'd0, 0, 0, 0, 0);
        do_access(0, 24'h10, 16'h0, 0, 0);
        chk("R8 narrow read", m_rd, 16'h005A);
        chk("R9 bhe narrow", m_bhe, 1);
        do_access(1, 24'h10, 16'h9977, 0, 0);
        chk("R8 narrow oe", m_oe_strb, 2'b01);
        chk("R8 narrow data", m_out_strb[7:0], 8'h77);
    endtask

    task automatic t_turn();
        set_cfg(0, 1, 2'd3, 4'd0, 0, 0, 1, 0);
        do_access(0, 24'h40, 16'h0, 0, 0);
        chk("R10 turn not ready", m_rdy_done, 0);
        chk("R10 turn released", m_oe_done, 0);
        chk("R10 turn ends", m_rdy_next, 1);
        do_access(1, 24'h40, 16'h1, 0, 0);
        chk("R10 no turn on write", m_rdy_done, 1);
        cfg_turn = 1'b0;
        do_access(0, 24'h40, 16'h0, 0, 0);
        chk("R10 no turn when off", m_rdy_done, 1);
    endtask

    task automatic t_hold();
        int ale_seen;
        int ack_in_cycle;
        set_cfg(0, 1, 2'd3, 4'd4, 0, 0, 0, 0);
        @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        chk("R11 ack from idle", hold_ack, 1);
        chk("R11 addr float", bus_addr_oe, 0);
        chk("R11 strobe float", bus_strb_oe, 0);
        chk("R11 ready low", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h50; req_byte = 1'b0;
        ale_seen = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (bus_ale) ale_seen++;
        end
        chk("R11 requests stalled", ale_seen, 0);
        req_valid = 1'b0;
        hold_req = 1'b0;
        @(negedge clk);
        chk("R11 ack drops", hold_ack, 0);
        chk("R11 drivers back", bus_addr_oe, 1);
        // hold raised during a running cycle
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        hold_req = 1'b1;
        ack_in_cycle = 0;
        for (int k = 0; k < 50; k++) begin
            if (hold_ack) ack_in_cycle++;
            if (rsp_done) break;
            @(negedge clk);
        end
        chk("R11 no ack mid cycle", ack_in_cycle, 0);
        @(negedge clk);
        chk("R11 ack after cycle", hold_ack, 1);
        hold_req = 1'b0;
        @(negedge clk);
        chk("R11 ack released", hold_ack, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_demux();
        t_mux();
        t_widths();
        t_waits();
        t_delay();
        t_ready();
        t_lanes();
        t_turn();
        t_hold();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule